// File: doc/BRIEF.md
# SDRAM Read-Latency and Byte-Mask Timing Pipeline

This block tracks the data-bus timing of a single-data-rate SDRAM at the point where commands meet data. It takes read and write burst commands, the burst length, a CAS-latency select and two per-byte mask inputs. From these it works out the cycles in which the memory drives the 16-bit data bus and which bytes of a read beat are actually driven. It also works out which bytes of incoming write data are accepted in each cycle.

A read burst drives the bus for a programmed number of beats. The first beat comes two or three cycles after the command. If a new read is issued before the current burst runs out, the bus stays driven with no gap. A write, or a newer read, cuts short the beats of a read that have not yet been launched. Read beats already in the latency pipeline still come out.

The two masks act differently on the two directions. On reads a mask blanks the byte two cycles after it is sampled. On writes it blocks the byte in the same cycle. A read byte that is driven while a write byte is accepted is flagged as bus contention.

Top module: `sdram_dq_timing`

## Requirements
- R1: A read command accepted in cycle n drives `rd_oe` high starting in cycle n+2 when `cas3`=0, and in cycle n+3 when `cas3`=1.
- R2: A read burst drives `rd_oe` for exactly `len_m1`+1 consecutive cycles. After that, `rd_oe` falls low unless a later read extends it.
- R3: A read issued while an earlier read is still launching beats discards the older burst's unlaunched beats. The new burst's beats follow directly, with no idle cycle between the bursts.
- R4: `rd_byte_vld[0]` covers the low byte and `rd_byte_vld[1]` covers the high byte. Each is high exactly when `rd_oe` is high and the matching `dqm` bit was low two cycles earlier.
- R5: A write command in cycle n makes the write window span cycles n through n+`len_m1`, so the first beat is accepted in the command cycle itself.
- R6: Within the write window, `wr_byte_en[i]` is the inverse of `dqm[i]` in the same cycle. Outside the window it is low.
- R7: A write command discards all unlaunched read beats. Read beats launched before it still drive `rd_oe`. A read command ends any write window, starting in its own cycle.
- R8: `contend_err` is high in exactly the cycles where some byte has both `rd_byte_vld` and `wr_byte_en` high.
- R9: When `rd_cmd` and `wr_cmd` are both high, the cycle is treated as a write command and the read is ignored.
- R10: Synchronous active-high `rst` discards all pending read beats, write beats and mask history. In the cycle after reset, `rd_oe` and `rd_byte_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Read burst command |
| wr_cmd | input | 1 | Write burst command |
| len_m1 | input | $clog2(MAX_BURST) | Burst length minus one, sampled with a command |
| cas3 | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 cycles; change only while idle |
| dqm | input | 2 | Byte masks: bit 0 is the low byte, bit 1 is the high byte |
| rd_oe | output | 1 | Read beat occupies the data bus this cycle |
| rd_byte_vld | output | 2 | Per-byte read drive enables |
| wr_byte_en | output | 2 | Per-byte write data accept strobes |
| contend_err | output | 1 | A driven read byte overlaps an accepted write byte |

## Verification
A wrong remaining-beat count appears on `rd_oe` as a burst that is one beat short or long, or as a one-cycle hole between chained reads. This shows up CL cycles after the fault. A wrong stage tap in the latency pipeline shifts every first beat by one cycle. A slip in the mask history blanks the wrong beat two cycles after the mask edge. A leftover write count shows as `wr_byte_en` in the cycle of a following read. The bench model predicts all four outputs for every cycle, so each of these faults is caught at its first visible cycle.

// File: rtl/sdram_dq_timing.sv
module sdram_dq_timing #(
  parameter int MAX_BURST = 8,
  localparam int LW = $clog2(MAX_BURST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_cmd,
  input  logic          wr_cmd,
  input  logic [LW-1:0] len_m1,
  input  logic          cas3,
  input  logic [1:0]    dqm,
  output logic          rd_oe,
  output logic [1:0]    rd_byte_vld,
  output logic [1:0]    wr_byte_en,
  output logic          contend_err
);

  logic [LW:0] rd_left, wr_left;
  logic [1:0]  launch_q;
  logic [1:0]  mask_d1, mask_d2;
  logic        rd_go, wr_active;

  assign rd_go = rd_cmd & ~wr_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_left  <= '0;
      wr_left  <= '0;
      launch_q <= '0;
      mask_d1  <= '0;
      mask_d2  <= '0;
    end else begin
      if (wr_cmd) begin
        rd_left <= '0;
        wr_left <= {1'b0, len_m1};
      end else if (rd_go) begin
        rd_left <= {1'b0, len_m1} + 1'b1;
        wr_left <= '0;
      end else begin
        if (rd_left != '0) rd_left <= rd_left - 1'b1;
        if (wr_left != '0) wr_left <= wr_left - 1'b1;
      end
      launch_q <= {launch_q[0], rd_left != '0};
      mask_d1  <= dqm;
      mask_d2  <= mask_d1;
    end
  end

  assign rd_oe       = cas3 ? launch_q[1] : launch_q[0];
  assign rd_byte_vld = {2{rd_oe}} & ~mask_d2;
  assign wr_active   = wr_cmd | ((wr_left != '0) & ~rd_cmd);
  assign wr_byte_en  = {2{wr_active}} & ~dqm;
  assign contend_err = |(rd_byte_vld & wr_byte_en);

endmodule

module sdram_dq_timing_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_cmd,
  input logic       wr_cmd,
  input logic       cas3,
  input logic [1:0] dqm,
  input logic       rd_oe,
  input logic [1:0] rd_byte_vld,
  input logic [1:0] wr_byte_en,
  input logic       contend_err
);

  p_first_beat_cl2_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && !wr_cmd && !cas3) |-> ##2 rd_oe);

  p_first_beat_cl3_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && !wr_cmd && cas3) |-> ##3 rd_oe);

  p_rd_mask_lo_r4: assert property (@(posedge clk) disable iff (rst)
    dqm[0] |-> ##2 !rd_byte_vld[0]);

  p_rd_mask_hi_r4: assert property (@(posedge clk) disable iff (rst)
    dqm[1] |-> ##2 !rd_byte_vld[1]);

  p_wr_first_beat_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !dqm[0]) |-> wr_byte_en[0]);

  p_both_cmds_write_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && wr_cmd && !dqm[1]) |-> wr_byte_en[1]);

  p_err_needs_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    contend_err |-> (rd_oe && (wr_byte_en != 2'b00)));

  p_reset_release_r10: assert property (@(posedge clk)
    rst |=> (!rd_oe && rd_byte_vld == 2'b00));

endmodule

bind sdram_dq_timing sdram_dq_timing_chk u_chk (
  .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .cas3(cas3),
  .dqm(dqm), .rd_oe(rd_oe), .rd_byte_vld(rd_byte_vld),
  .wr_byte_en(wr_byte_en), .contend_err(contend_err)
);

// File: tb/sdram_dq_timing_bench.sv
module sdram_dq_timing_bench;
  localparam int MB = 8;
  localparam int LW = $clog2(MB);
  localparam int NC = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1, rd_cmd = 1'b0, wr_cmd = 1'b0, cas3 = 1'b0;
  logic [LW-1:0] len_m1 = '0;
  logic [1:0]    dqm = 2'b00;
  logic          rd_oe, contend_err;
  logic [1:0]    rd_byte_vld, wr_byte_en;

  sdram_dq_timing #(.MAX_BURST(MB)) u_sdram_dq_timing (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .len_m1(len_m1),
    .cas3(cas3), .dqm(dqm), .rd_oe(rd_oe), .rd_byte_vld(rd_byte_vld),
    .wr_byte_en(wr_byte_en), .contend_err(contend_err)
  );

  int   cyc = 0, errors = 0, checks = 0;
  bit   done = 0;
  bit   cl3 = 0;
  bit   oe_plan [NC];
  bit   wr_plan [NC];
  logic [1:0] mask_h [NC];
  logic [31:0] lfsr = 32'h1ACE_5EED;

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit w, input int len, input logic [1:0] m, input bit rs);
    int c, lat;
    logic [1:0] pm, e_vld, e_wr;
    bit e_oe;
    @(posedge clk);
    #1;
    rd_cmd = r; wr_cmd = w; len_m1 = LW'(len - 1); cas3 = cl3; dqm = m; rst = rs;
    cyc++;
    c = cyc;
    lat = cl3 ? 3 : 2;
    mask_h[c] = m;
    if (rs) begin
      for (int i = c + 1; i < NC; i++) begin oe_plan[i] = 0; wr_plan[i] = 0; end
      mask_h[c] = 2'b00;
      mask_h[c-1] = 2'b00;
    end else if (w) begin
      for (int i = c; i < NC; i++) wr_plan[i] = 0;
      for (int k = 0; k < len; k++) wr_plan[c+k] = 1;
      for (int i = c + lat; i < NC; i++) oe_plan[i] = 0;
    end else if (r) begin
      for (int i = c; i < NC; i++) wr_plan[i] = 0;
      for (int i = c + lat; i < NC; i++) oe_plan[i] = 0;
      for (int k = 0; k < len; k++) oe_plan[c+lat+k] = 1;
    end
    @(negedge clk);
    e_oe  = oe_plan[c];
    pm    = (c >= 2) ? mask_h[c-2] : 2'b00;
    e_vld = {2{e_oe}} & ~pm;
    e_wr  = {2{wr_plan[c]}} & ~m;
    chk({1'b0, rd_oe}, {1'b0, e_oe}, "R1 R2 R3 R7 R10 rd_oe");
    chk(rd_byte_vld, e_vld, "R4 R10 rd_byte_vld");
    chk(wr_byte_en, e_wr, "R5 R6 R7 R9 wr_byte_en");
    chk({1'b0, contend_err}, {1'b0, |(e_vld & e_wr)}, "R8 contend_err");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 2'b00, 0);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin oe_plan[i] = 0; wr_plan[i] = 0; mask_h[i] = 2'b00; end
    repeat (3) step(0, 0, 1, 2'b00, 1);
    idle(2);
    // R1 R2: single bursts at both latencies
    cl3 = 0; step(1, 0, 4, 2'b00, 0); idle(8);
    cl3 = 1; step(1, 0, 1, 2'b00, 0); idle(6);
    step(1, 0, 8, 2'b00, 0);
    step(0, 0, 1, 2'b01, 0); step(0, 0, 1, 2'b10, 0); step(0, 0, 1, 2'b11, 0);
    idle(10);
    // R3: chained reads, gapless
    cl3 = 0;
    for (int i = 0; i < 4; i++) begin step(1, 0, 2, 2'b00, 0); step(0, 0, 1, 2'b00, 0); end
    idle(6);
    cl3 = 1; step(1, 0, 8, 2'b00, 0); idle(2); step(1, 0, 3, 2'b10, 0); idle(8);
    // R5 R6: write with masks
    step(0, 1, 4, 2'b01, 0); step(0, 0, 1, 2'b10, 0); step(0, 0, 1, 2'b00, 0); idle(4);
    // R7 R8: write interrupting a read, unmasked then masked
    cl3 = 0; step(1, 0, 8, 2'b00, 0); idle(2); step(0, 1, 3, 2'b00, 0); idle(6);
    step(1, 0, 8, 2'b00, 0); idle(1); step(0, 0, 1, 2'b11, 0); step(0, 1, 4, 2'b11, 0);
    step(0, 0, 1, 2'b00, 0); idle(6);
    // R7: read cutting a write
    step(0, 1, 8, 2'b00, 0); idle(2); step(1, 0, 2, 2'b00, 0); idle(6);
    // R9: both commands together
    step(1, 1, 3, 2'b00, 0); idle(6);
    // R10: reset in the middle of bursts
    cl3 = 1; step(1, 0, 8, 2'b00, 0); idle(1); step(0, 0, 1, 2'b00, 1); idle(6);
    step(0, 1, 8, 2'b00, 0); step(0, 0, 1, 2'b00, 1); idle(4);
    // mixed traffic
    for (int blk = 0; blk < 4; blk++) begin
      cl3 = blk[0];
      for (int i = 0; i < 300; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        step(lfsr[3:2] == 2'b00, lfsr[6:4] == 3'b000, int'(lfsr[10:8]) + 1,
             lfsr[12:11], lfsr[20:13] == 8'h00);
      end
      idle(14);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule